// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Staged Commit

The block drives four independent pulse-width modulated outputs. Software reaches it through one register port made of an address, write data, a write strobe and a read strobe. Each channel owns four registers: a clock divider, a period length counted in divided steps, a high-time length counted in the same steps, and an on/off switch. Each period starts with the output high for the high-time steps and then keeps it low for the rest of the period.

Divider, period and high-time values are first written into a staging copy. Writing the high-time register marks the staged set as ready to commit. A running channel keeps its current period intact and switches to the new set only at the next period boundary, so no period ever mixes old and new settings. Switching a channel off takes effect straight away, without waiting for the period to end. Software therefore writes divider and period first and the high-time value last.

Top module: `pwm_quad`

## Requirements
- R1: Channel c occupies addresses c*0x20 to c*0x20+0x1F. The offsets are: divider at 0x00 (bits 7:0), period at 0x04 (bits 7:0), high time at 0x08 (bits 15:0), on/off at 0x18 (bit 0). A read strobe returns the most recently written (staged) value on `bus_rdata` one cycle later. The unused upper bits read as zero. Without a read strobe, `bus_rdata` is zero.
- R2: Every other offset inside a channel window reads as zero. A write to such an offset changes no register and no output.
- R3: With committed divider P, period M and high time D, with D below M, one period lasts (P+1)*M clock cycles. The first (P+1)*D cycles of the period are high and the rest are low. A period value of 0 acts as 1.
- R4: Writes to the divider or period registers alone never change the running waveform. Only a write to the high-time register commits the staged set.
- R5: On a running channel, a committed set takes effect at the first period boundary after the commit. The period in progress completes with the old settings.
- R6: If D is at least M, the output stays high for the whole period. If D is 0, the output stays low.
- R7: Writing 0 to the on/off bit drives the output low from the second clock edge after the write and resets the channel's counters.
- R8: Writing 1 to the on/off bit of a stopped channel starts a new period from step zero. A set committed while the channel was stopped applies at once, so it is used from the first period. A stopped channel's output is low.
- R9: A synchronous active-high reset clears every register, stops every channel and drives every output and `bus_rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock for the register port and all counters |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 7 | Byte address: channel index in bits 6:5, register offset in bits 4:0 |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe; data appears on the following cycle |
| bus_rdata | output | 16 | Registered read data |
| pwm_out | output | 4 | Registered waveform, one bit per channel |

## Verification
The embedded properties check, on every cycle, the invariants that need no history. The step and divider counters never pass their committed limits. A running channel's active settings change only at a period boundary. A commit write always leaves a change pending. A stopped channel's output is low on the next cycle. An idle read port returns zero. The whole-waveform behaviour comes only from the bench's scenarios, checked cycle by cycle against an independent model. This covers the exact high and low cycle counts, the deferral of a mid-period commit to the boundary, the full-high and full-low extremes, restart on enable, and the silence of unmapped offsets.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  // Register offsets inside one 32-byte channel window
  localparam logic [4:0] OFF_DIV  = 5'h00;
  localparam logic [4:0] OFF_PER  = 5'h04;
  localparam logic [4:0] OFF_HIGH = 5'h08;
  localparam logic [4:0] OFF_RUN  = 5'h18;
  localparam int         WIN_BITS = 5;

  typedef struct packed {
    logic div;
    logic per;
    logic high;
    logic run;
  } wr_strobe_t;
endpackage

// File: rtl/pwm_chan_cfg.sv
module pwm_chan_cfg
  import pwm_quad_pkg::*;
#(
  parameter int PSC_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_strobe_t        wr,
  input  logic [DUTY_W-1:0] wdata,
  input  logic              period_end,
  output logic [PSC_W-1:0]  stg_div,
  output logic [MOD_W-1:0]  stg_per,
  output logic [DUTY_W-1:0] stg_high,
  output logic              run,
  output logic              restart,
  output logic [PSC_W-1:0]  act_div,
  output logic [MOD_W-1:0]  act_per,
  output logic [DUTY_W-1:0] act_high
);
  logic pend;

  // A change of the run bit in either direction restarts the counters
  assign restart = wr.run && (wdata[0] != run);

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_div  <= '0;
      stg_per  <= '0;
      stg_high <= '0;
      act_div  <= '0;
      act_per  <= '0;
      act_high <= '0;
      run      <= 1'b0;
      pend     <= 1'b0;
    end else begin
      // Apply a waiting set at a period boundary, or at once when stopped
      if (pend && (!run || period_end)) begin
        act_div  <= stg_div;
        act_per  <= stg_per;
        act_high <= stg_high;
        pend     <= 1'b0;
      end
      if (wr.div) stg_div <= wdata[PSC_W-1:0];
      if (wr.per) stg_per <= wdata[MOD_W-1:0];
      if (wr.high) begin
        stg_high <= wdata;
        pend     <= 1'b1;
      end
      if (wr.run) run <= wdata[0];
    end
  end

  // R5: active settings of a running channel move only at a boundary
  p_hold_active_r5: assert property (@(posedge clk) disable iff (rst)
    (run && !period_end) |=> ($stable(act_high) && $stable(act_per) && $stable(act_div)));

  // R4: a high-time write always leaves a commit waiting
  p_commit_pending_r4: assert property (@(posedge clk) disable iff (rst)
    wr.high |=> pend);

  // R5: a boundary consumes a waiting commit unless a new one arrives
  p_commit_applied_r5: assert property (@(posedge clk) disable iff (rst)
    (pend && period_end && !wr.high) |=> !pend);
endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen #(
  parameter int PSC_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic [PSC_W-1:0]  act_div,
  input  logic [MOD_W-1:0]  act_per,
  input  logic [DUTY_W-1:0] act_high,
  output logic              period_end,
  output logic              wave
);
  logic [PSC_W-1:0] pre_cnt;
  logic [MOD_W-1:0] step_cnt;
  logic             last_pre;
  logic             last_step;

  assign last_pre   = (pre_cnt == act_div);
  assign last_step  = ((MOD_W+1)'(step_cnt) + (MOD_W+1)'(1)) >= (MOD_W+1)'(act_per);
  assign period_end = run && last_pre && last_step;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_cnt  <= '0;
      step_cnt <= '0;
    end else if (run) begin
      if (last_pre) begin
        pre_cnt  <= '0;
        step_cnt <= last_step ? '0 : step_cnt + MOD_W'(1);
      end else begin
        pre_cnt <= pre_cnt + PSC_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wave <= 1'b0;
    else     wave <= run && (DUTY_W'(step_cnt) < act_high);
  end

  // R3: divider count never passes its committed limit
  p_pre_bound_r3: assert property (@(posedge clk) disable iff (rst)
    run |-> (pre_cnt <= act_div));

  // R3: step count stays inside the period (a zero period acts as one)
  p_step_bound_r3: assert property (@(posedge clk) disable iff (rst)
    run |-> ((step_cnt < act_per) || (step_cnt == '0)));

  // R7/R8: a stopped channel is low on the next cycle
  p_off_low_r7: assert property (@(posedge clk) disable iff (rst)
    !run |=> !wave);
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int PSC_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW    = CH_W + WIN_BITS,
  localparam int DW    = DUTY_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  input  logic           bus_we,
  input  logic           bus_re,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  logic [CH_W-1:0]     ch_sel;
  logic [WIN_BITS-1:0] off;
  logic [DW-1:0]       rd_word [NCH];

  assign ch_sel = bus_addr[AW-1:WIN_BITS];
  assign off    = bus_addr[WIN_BITS-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wr_strobe_t        wr;
    logic              hit;
    logic [PSC_W-1:0]  stg_div, act_div;
    logic [MOD_W-1:0]  stg_per, act_per;
    logic [DUTY_W-1:0] stg_high, act_high;
    logic              run, restart, period_end;

    assign hit     = bus_we && (ch_sel == CH_W'(g));
    assign wr.div  = hit && (off == OFF_DIV);
    assign wr.per  = hit && (off == OFF_PER);
    assign wr.high = hit && (off == OFF_HIGH);
    assign wr.run  = hit && (off == OFF_RUN);

    pwm_chan_cfg #(.PSC_W(PSC_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W)) u_cfg (
      .clk(clk), .rst(rst), .wr(wr), .wdata(bus_wdata), .period_end(period_end),
      .stg_div(stg_div), .stg_per(stg_per), .stg_high(stg_high),
      .run(run), .restart(restart),
      .act_div(act_div), .act_per(act_per), .act_high(act_high)
    );

    pwm_wave_gen #(.PSC_W(PSC_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W)) u_gen (
      .clk(clk), .rst(rst), .run(run), .restart(restart),
      .act_div(act_div), .act_per(act_per), .act_high(act_high),
      .period_end(period_end), .wave(pwm_out[g])
    );

    always_comb begin
      case (off)
        OFF_DIV:  rd_word[g] = DW'(stg_div);
        OFF_PER:  rd_word[g] = DW'(stg_per);
        OFF_HIGH: rd_word[g] = stg_high;
        OFF_RUN:  rd_word[g] = DW'(run);
        default:  rd_word[g] = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_re) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      for (int i = 0; i < NCH; i++)
        if (ch_sel == CH_W'(i)) bus_rdata <= rd_word[i];
    end
  end

  // R1: an idle read port returns zero on the next cycle
  p_rdata_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> (bus_rdata == '0));
endmodule

// File: tb/pwm_quad_test.sv
`timescale 1ns/1ps
module pwm_quad_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [15:0] bus_rdata;
  logic [3:0]  pwm_out;

  always #2 clk = ~clk;

  pwm_quad uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  int vectors = 0;
  int miscompares = 0;
  bit armed = 0;
  bit done = 0;
  string cur_req = "R9";

  // Behavioural model: a position counter inside each period
  int m_sdiv[4], m_sper[4], m_shigh[4];
  int m_adiv[4], m_aper[4], m_ahigh[4];
  int m_pos[4];
  bit m_run[4], m_pend[4];
  logic [3:0]  exp_out = '0;
  logic [15:0] exp_rdata = '0;

  function automatic int model_read(int a);
    int ch, o;
    ch = a >> 5;
    o  = a & 31;
    if (ch > 3) return 0;
    case (o)
      'h00: return m_sdiv[ch];
      'h04: return m_sper[ch];
      'h08: return m_shigh[ch];
      'h18: return int'(m_run[ch]);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    armed = 1;
    if (rst) begin
      exp_out   = '0;
      exp_rdata = '0;
      for (int c = 0; c < 4; c++) begin
        m_sdiv[c] = 0; m_sper[c] = 0; m_shigh[c] = 0;
        m_adiv[c] = 0; m_aper[c] = 0; m_ahigh[c] = 0;
        m_pos[c] = 0; m_run[c] = 0; m_pend[c] = 0;
      end
    end else begin
      for (int c = 0; c < 4; c++)
        exp_out[c] = m_run[c] && (m_pos[c] < (m_adiv[c] + 1) * m_ahigh[c]);
      exp_rdata = bus_re ? 16'(model_read(int'(bus_addr))) : '0;
      for (int c = 0; c < 4; c++) begin
        bit apply;
        apply = 0;
        if (m_run[c]) begin
          int len;
          len = (m_adiv[c] + 1) * ((m_aper[c] == 0) ? 1 : m_aper[c]);
          m_pos[c]++;
          if (m_pos[c] >= len) begin
            m_pos[c] = 0;
            apply = m_pend[c];
          end
        end else begin
          apply = m_pend[c];
        end
        if (apply) begin
          m_adiv[c] = m_sdiv[c]; m_aper[c] = m_sper[c]; m_ahigh[c] = m_shigh[c];
          m_pend[c] = 0;
        end
      end
      if (bus_we) begin
        int ch, o, d;
        ch = int'(bus_addr) >> 5;
        o  = int'(bus_addr) & 31;
        d  = int'(bus_wdata);
        case (o)
          'h00: m_sdiv[ch] = d & 255;
          'h04: m_sper[ch] = d & 255;
          'h08: begin m_shigh[ch] = d; m_pend[ch] = 1; end
          'h18: begin
            if ((d & 1) == 1 && !m_run[ch]) begin m_run[ch] = 1; m_pos[ch] = 0; end
            else if ((d & 1) == 0) begin m_run[ch] = 0; m_pos[ch] = 0; end
          end
          default: ;
        endcase
      end
    end
  end

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      vectors++;
      if (pwm_out !== exp_out) begin
        miscompares++;
        $display("FAIL %s pwm_out actual=%b expected=%b at %0t", cur_req, pwm_out, exp_out, $time);
      end
      if (bus_rdata !== exp_rdata) begin
        miscompares++;
        $display("FAIL %s bus_rdata actual=%h expected=%h at %0t", cur_req, bus_rdata, exp_rdata, $time);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 7'(a); bus_wdata = 16'(d); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    bus_addr = 7'(a); bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired during %s", cur_req);
    finish_run();
  end

  initial begin
    // R9: reset state
    cur_req = "R9";
    idle(3);
    rst = 1'b0;
    for (int c = 0; c < 4; c++) rd(c * 32 + 'h08);
    idle(2);

    // R3: divider 1, period 4, high 2 on channel 0
    cur_req = "R3";
    wr('h00, 1); wr('h04, 4); wr('h08, 2); wr('h18, 1);
    idle(40);

    // R6: high >= period stays high; high 0 stays low
    cur_req = "R6";
    wr(32 + 'h00, 0); wr(32 + 'h04, 5); wr(32 + 'h08, 7); wr(32 + 'h18, 1);
    wr(64 + 'h04, 6); wr(64 + 'h08, 0); wr(64 + 'h18, 1);
    idle(30);

    // R4: period change without a commit leaves the waveform unchanged
    cur_req = "R4";
    wr('h04, 9); wr('h00, 0);
    idle(30);

    // R5: commit in the middle of a period applies at the boundary
    cur_req = "R5";
    idle(3);
    wr('h08, 3);
    idle(40);
    wr(32 + 'h04, 10); wr(32 + 'h08, 4);
    idle(30);

    // R7: stop a channel mid-period
    cur_req = "R7";
    idle(2);
    wr('h18, 0);
    idle(10);

    // R8: commit while stopped, then restart; zero period acts as one (R3)
    cur_req = "R8";
    wr(96 + 'h00, 2); wr(96 + 'h04, 0); wr(96 + 'h08, 1); wr(96 + 'h18, 1);
    idle(20);
    wr(96 + 'h04, 3); wr(96 + 'h08, 2);
    idle(20);
    wr('h00, 2); wr('h04, 3); wr('h08, 1);
    idle(5);
    wr('h18, 1);
    idle(30);

    // R1: read back every staged register of every channel
    cur_req = "R1";
    for (int c = 0; c < 4; c++) begin
      rd(c * 32 + 'h00); rd(c * 32 + 'h04); rd(c * 32 + 'h08); rd(c * 32 + 'h18);
    end

    // R2: unmapped offsets ignore writes and read zero
    cur_req = "R2";
    wr('h0C, 16'hFFFF); wr('h10, 16'h00FF); wr(32 + 'h1C, 16'h1234); wr(64 + 'h14, 16'h0001);
    rd('h0C); rd('h10); rd(32 + 'h1C); rd(64 + 'h14); rd(96 + 'h02);
    rd('h00); rd('h04); rd('h08); rd(64 + 'h18);
    idle(20);

    // R9: reset in the middle of activity
    cur_req = "R9";
    @(negedge clk); rst = 1'b1;
    idle(2);
    rst = 1'b0;
    rd(32 + 'h08); rd(96 + 'h18);
    idle(10);

    finish_run();
  end
endmodule